// File: doc/BRIEF.md
# Dual-Rate Periodic Tick Timer

This block is a free-running time base for a small controller that runs from a 6 MHz clock. A prescaler divides the clock down to a 128 µs tick. Each tick advances an 8-bit count register that software can read. Each tick also raises a latched "fast" request. On every eighth tick, when the low three bits of the count return to zero, the block also raises a latched "slow" request, which gives a 1.024 ms period. The two rates come from one divider chain, so the slow event always falls on a fast tick.

Each request stays pending until its own clear strobe arrives. The interrupt arbitration logic outside the block reads the two flags and acknowledges each one separately. While `suspend` is high the prescaler and the count are frozen and no new request is raised. The clear strobes still act during suspend.

Top module: `dual_rate_tick_timer`

## Requirements
- R1: In the cycle after a synchronous reset, `count_o` is 0 and both `fast_pend` and `slow_pend` are 0.
- R2: `count_o` increases by exactly one after every PRESCALE clock edges at which `suspend` is low (default 768, which is 128 µs at 6 MHz), and changes at no other time.
- R3: `count_o` wraps from 255 to 0 and keeps counting.
- R4: `fast_pend` becomes 1 at the same clock edge at which `count_o` advances.
- R5: `slow_pend` becomes 1 at the edge at which `count_o` advances to a value whose low three bits are 000, which is once per eight fast ticks.
- R6: Each flag stays 1 until its own clear input is high at a clock edge. `fast_clr` has no effect on `slow_pend`, and `slow_clr` has no effect on `fast_pend`.
- R7: If a flag's set event and its clear strobe fall on the same edge, the flag ends up 1.
- R8: While `suspend` is high at an edge, the prescaler and `count_o` hold their values and no flag is set. A clear strobe at that edge still clears its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock (6 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| suspend | input | 1 | High freezes all counting and flag setting |
| fast_clr | input | 1 | Clears the 128 µs request flag |
| slow_clr | input | 1 | Clears the 1.024 ms request flag |
| count_o | output | 8 | Readable tick count |
| fast_pend | output | 1 | Pending 128 µs request |
| slow_pend | output | 1 | Pending 1.024 ms request |

## Verification
The main collision is a tick, which sets a flag, landing on the same edge as a software clear of that flag. The second is a clear arriving while suspend has frozen the set path. The bench uses a short prescale and random clear strobes at a high rate, so both fast ticks and eighth-tick slow events often meet a clear. It judges each such edge against the rule that the set wins. Random bursts of suspend check that the count holds while the clears still take effect.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int unsigned DEF_PRESCALE  = 768;
    localparam int unsigned DEF_CNT_W     = 8;
    localparam int unsigned DEF_SLOW_LOG2 = 3;

    typedef struct packed {
        logic fast;
        logic slow;
    } tick_evt_t;

    typedef enum logic [0:0] {
        SRC_FAST = 1'b0,
        SRC_SLOW = 1'b1
    } tick_src_e;

    function automatic logic flag_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int unsigned PRESCALE = tick_pkg::DEF_PRESCALE
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre_q;

    assign tick = run && (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int unsigned CNT_W     = tick_pkg::DEF_CNT_W,
    parameter int unsigned SLOW_LOG2 = tick_pkg::DEF_SLOW_LOG2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    output logic [CNT_W-1:0]    count,
    output tick_pkg::tick_evt_t evt
);
    localparam logic [SLOW_LOG2-1:0] GRP_END = '1;

    logic [CNT_W-1:0] cnt_q;

    assign count    = cnt_q;
    assign evt.fast = tick;
    assign evt.slow = tick && (cnt_q[SLOW_LOG2-1:0] == GRP_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tick_flag.sv
module tick_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else begin
            pend <= tick_pkg::flag_next(pend, set, clr);
        end
    end
endmodule

// File: rtl/dual_rate_tick_timer.sv
module dual_rate_tick_timer #(
    parameter int unsigned PRESCALE  = tick_pkg::DEF_PRESCALE,
    parameter int unsigned CNT_W     = tick_pkg::DEF_CNT_W,
    parameter int unsigned SLOW_LOG2 = tick_pkg::DEF_SLOW_LOG2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             suspend,
    input  logic             fast_clr,
    input  logic             slow_clr,
    output logic [CNT_W-1:0] count_o,
    output logic             fast_pend,
    output logic             slow_pend
);
    localparam int unsigned NSRC = 2;

    logic                tick;
    tick_pkg::tick_evt_t evt;
    logic [NSRC-1:0]     set_v;
    logic [NSRC-1:0]     clr_v;
    logic [NSRC-1:0]     pend_v;

    tick_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (~suspend),
        .tick (tick)
    );

    tick_counter #(.CNT_W(CNT_W), .SLOW_LOG2(SLOW_LOG2)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .count (count_o),
        .evt   (evt)
    );

    assign set_v[tick_pkg::SRC_FAST] = evt.fast;
    assign set_v[tick_pkg::SRC_SLOW] = evt.slow;
    assign clr_v[tick_pkg::SRC_FAST] = fast_clr;
    assign clr_v[tick_pkg::SRC_SLOW] = slow_clr;

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        tick_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .set  (set_v[i]),
            .clr  (clr_v[i]),
            .pend (pend_v[i])
        );
    end

    assign fast_pend = pend_v[tick_pkg::SRC_FAST];
    assign slow_pend = pend_v[tick_pkg::SRC_SLOW];
endmodule

// File: rtl/dual_rate_tick_timer_chk.sv
module dual_rate_tick_timer_chk #(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned SLOW_LOG2 = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             suspend,
    input logic             fast_clr,
    input logic             slow_clr,
    input logic [CNT_W-1:0] count_o,
    input logic             fast_pend,
    input logic             slow_pend
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 1'b1)); // R2

    AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && suspend) |-> $stable(count_o)); // R8

    AST_FAST_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        (count_o != $past(count_o)) |-> fast_pend); // R4

    AST_SLOW_ALIGN: assert property (@(posedge clk) disable iff (rst)
        $rose(slow_pend) |-> (count_o[SLOW_LOG2-1:0] == '0)); // R5

    AST_FAST_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && fast_pend && !fast_clr) |-> fast_pend); // R6

    AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && slow_pend && !slow_clr) |-> slow_pend); // R6
endmodule

bind dual_rate_tick_timer dual_rate_tick_timer_chk #(
    .CNT_W(CNT_W), .SLOW_LOG2(SLOW_LOG2)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .suspend   (suspend),
    .fast_clr  (fast_clr),
    .slow_clr  (slow_clr),
    .count_o   (count_o),
    .fast_pend (fast_pend),
    .slow_pend (slow_pend)
);

// File: tb/dual_rate_tick_timer_bench.sv
module dual_rate_tick_timer_bench;
    localparam int unsigned PS = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       suspend = 1'b0;
    logic       fast_clr = 1'b0;
    logic       slow_clr = 1'b0;
    logic [7:0] count_o;
    logic       fast_pend;
    logic       slow_pend;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_rate_tick_timer #(.PRESCALE(PS)) u_dual_rate_tick_timer (
        .clk(clk), .rst(rst), .suspend(suspend),
        .fast_clr(fast_clr), .slow_clr(slow_clr),
        .count_o(count_o), .fast_pend(fast_pend), .slow_pend(slow_pend)
    );

    // reference state, from the requirements
    int unsigned m_run;     // enabled edges since last tick
    logic [7:0]  m_cnt;
    logic        m_fast, m_slow;
    logic        m_fast_coll, m_slow_coll, m_was_susp, m_wrapped;

    function automatic logic ref_flag(input logic cur, input logic set, input logic clr);
        if (set) return 1'b1;        // R7: set wins
        if (clr) return 1'b0;
        return cur;
    endfunction

    always @(posedge clk) begin
        logic tk, sl;
        if (rst) begin
            m_run <= 0; m_cnt <= 0; m_fast <= 0; m_slow <= 0;
            m_fast_coll <= 0; m_slow_coll <= 0; m_was_susp <= 0; m_wrapped <= 0;
        end else begin
            tk = !suspend && (m_run == PS - 1);
            sl = tk && ((m_cnt % 8) == 7);
            if (!suspend) m_run <= tk ? 0 : m_run + 1;
            if (tk) m_cnt <= m_cnt + 8'd1;
            m_wrapped   <= tk && (m_cnt == 8'd255);
            m_fast      <= ref_flag(m_fast, tk, fast_clr);
            m_slow      <= ref_flag(m_slow, sl, slow_clr);
            m_fast_coll <= tk && fast_clr;
            m_slow_coll <= sl && slow_clr;
            m_was_susp  <= suspend;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    int wraps = 0, fcoll = 0, scoll = 0;

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1;
        repeat (3) @(negedge clk);
        fast_clr = 1'b1; slow_clr = 1'b1;
        @(negedge clk);
        chk("R1", "count after reset", count_o, 0);
        chk("R1", "fast after reset", fast_pend, 0);
        chk("R1", "slow after reset", slow_pend, 0);
        rst = 1'b0; fast_clr = 1'b0; slow_clr = 1'b0;

        for (int cyc = 0; cyc < 9000; cyc++) begin
            @(negedge clk);
            if (m_was_susp)
                chk("R8", "count frozen", count_o, m_cnt);
            else if (m_wrapped) begin
                chk("R3", "count wrap", count_o, m_cnt);
                wraps++;
            end else
                chk("R2", "count", count_o, m_cnt);
            if (m_fast_coll) begin
                chk("R7", "fast set vs clear", fast_pend, m_fast); fcoll++;
            end else
                chk(m_was_susp ? "R8" : "R4", "fast flag", fast_pend, m_fast);
            if (m_slow_coll) begin
                chk("R7", "slow set vs clear", slow_pend, m_slow); scoll++;
            end else
                chk(m_was_susp ? "R8" : "R5", "slow flag", slow_pend, m_slow);
            chk("R6", "flags independent", {fast_pend, slow_pend}, {m_fast, m_slow});
            // drive next inputs
            if (cyc >= 3000 && cyc < 3400) suspend = ($urandom % 4) != 0;
            else suspend = ($urandom % 16) == 0;
            fast_clr = (cyc < 1500) ? 1'b0 : (($urandom % 3) == 0);
            slow_clr = (cyc < 1500) ? 1'b0 : (($urandom % 3) == 0);
        end
        chk("R3", "wrap seen", (wraps > 0) ? 1 : 0, 1);
        chk("R7", "fast collisions seen", (fcoll > 0) ? 1 : 0, 1);
        chk("R7", "slow collisions seen", (scoll > 0) ? 1 : 0, 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule